// File: doc/BRIEF.md
# PCM Transmit Timeslot Serializer

This block puts one 8-bit PCM word per frame onto the serial transmit line of a telephony codec channel. A companding encoder hands it words through a valid/ready port. The block sends each word, most significant bit first, in a timeslot that opens on a rising edge of frame sync. Bit timing comes from one of two sources. In fixed-rate mode the system clock, which is the transmit master clock, paces every bit, and a timeslot strobe output marks the word. In variable-rate mode an external data clock paces the bits and frame sync acts as a timeslot enable.

In fixed-rate mode the width of the frame-sync pulse tells normal frames from signalling frames. In a signalling frame the last bit of the word is replaced by a signalling input, unless A-law operation is selected. A frame sync that stays low long enough puts the channel in standby. The output enable is active only for the bit periods of a timeslot. The word port holds one entry. The port stalls (ready low) from the moment a word is accepted until a timeslot takes that word, and the upstream encoder must hold its valid and data during the stall. When no fresh word is waiting at a timeslot, the block sends the previous word again.

Top module: `pcm_tx_slot_serializer`

## Requirements
- R1: After reset, dx_oe, dx, ts_strobe and standby are 0 and word_ready is 1.
- R2: In fixed mode (rate_sel=0) there is a bit tick on every clock. A tick on which fs is sampled 1 after a 0 sample, while no timeslot is open, opens a timeslot. From the next cycle, dx_oe is 1 for exactly 8 cycles and dx carries the word, bit 7 first and bit 0 last.
- R3: In variable mode (rate_sel=1) a rising edge of dclk_ext that is first sampled high at clock edge n gives a tick at edge n+2. Bits advance only on ticks. A tick that samples fs low while a timeslot is open closes it early.
- R4: In fixed mode, if fs is still 1 on the second tick of a timeslot, the frame is a signalling frame. The last bit sent is then the value of sig_in sampled on the opening tick, not word bit 0.
- R5: With alaw_sel=1, no substitution takes place, and bit 0 of the word is sent in every frame.
- R6: In variable mode no frame is a signalling frame, so bit 0 of the word is always sent.
- R7: ts_strobe equals dx_oe in fixed mode and is 0 in variable mode. While dx_oe is 0, dx is 0.
- R8: A word is accepted on a clock where word_valid and word_ready are both 1. word_ready then stays 0 until a timeslot opens and takes the stored word.
- R9: A timeslot that opens with no stored word sends the word of the previous timeslot again (0 if none has been sent yet).
- R10: standby rises at the edge that samples fs low for the LOSS_CYCLES-th consecutive clock. It falls at the edge that samples fs high. While standby is 1, dx_oe is 0, and a timeslot still open when standby rises is closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the transmit master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rate_sel | input | 1 | 0 = fixed-rate, 1 = variable-rate |
| alaw_sel | input | 1 | 1 = A-law operation, signalling substitution off |
| dclk_ext | input | 1 | External data clock for variable mode |
| fs | input | 1 | Frame sync / timeslot enable |
| sig_in | input | 1 | Signalling bit to send in signalling frames |
| word_data | input | WORD_W | Parallel PCM word from the encoder |
| word_valid | input | 1 | word_data is offered |
| word_ready | output | 1 | Block can take a word |
| dx | output | 1 | Serial transmit data |
| dx_oe | output | 1 | Enable for the transmit line driver |
| ts_strobe | output | 1 | Timeslot strobe, fixed mode only |
| standby | output | 1 | Frame sync lost |

## Verification
The assertions assume that rate_sel and alaw_sel change only while no timeslot is open, and that a stalled encoder keeps word_valid and word_data steady until the transfer. In variable mode they also assume that fs changes only together with falling dclk edges. The bench changes the mode pins only in idle gaps and drives fs at the same clock as each falling dclk edge. Its push task holds valid and data until ready is seen. A cycle-level model then predicts dx, dx_oe, ts_strobe, word_ready and standby across all these cases.

// File: rtl/pcm_tx_pkg.sv
package pcm_tx_pkg;
  typedef enum logic {
    RATE_FIXED    = 1'b0,
    RATE_VARIABLE = 1'b1
  } rate_e;
endpackage

// File: rtl/pcm_tx_bit_clock.sv
module pcm_tx_bit_clock
  import pcm_tx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic  clk,
  input  logic  rst_n,
  input  rate_e rate,
  input  logic  dclk_ext,
  output logic  tick
);
  // sync_q[SYNC_STAGES] is the extra stage used for edge detection
  logic [SYNC_STAGES:0] sync_q;
  logic                 var_tick;

  generate
    for (genvar g = 0; g <= SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) sync_q[0] <= 1'b0;
          else        sync_q[0] <= dclk_ext;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) sync_q[g] <= 1'b0;
          else        sync_q[g] <= sync_q[g-1];
      end
    end
  endgenerate

  assign var_tick = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];
  assign tick     = (rate == RATE_FIXED) ? 1'b1 : var_tick;

  // R3: an external edge yields a single tick, never two in a row
  p_var_tick_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rate == RATE_VARIABLE && tick) |=> (!tick || rate == RATE_FIXED));
endmodule

// File: rtl/pcm_tx_word_buffer.sv
module pcm_tx_word_buffer #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              take,
  output logic [WORD_W-1:0] word_out
);
  logic [WORD_W-1:0] hold_q, last_q;
  logic              full_q;
  logic              accept;

  assign in_ready = ~full_q;
  assign accept   = in_valid & ~full_q;
  assign word_out = full_q ? hold_q : last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      last_q <= '0;
      full_q <= 1'b0;
    end else begin
      if (accept) begin
        hold_q <= in_data;
        full_q <= 1'b1;
      end else if (take) begin
        full_q <= 1'b0;
      end
      if (take) last_q <= word_out;
    end
  end

  // R8: a stored word stays put until a timeslot consumes it
  p_hold_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && !take) |=> (full_q && $stable(hold_q)));
  // R8: a stalled offer does not disturb the stored word
  p_no_accept_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready && !take) |=> $stable(hold_q));
endmodule

// File: rtl/pcm_tx_slot_shifter.sv
module pcm_tx_slot_shifter
  import pcm_tx_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  rate_e             rate,
  input  logic              alaw_sel,
  input  logic              fs,
  input  logic              sig_in,
  input  logic              standby,
  input  logic [WORD_W-1:0] word_in,
  output logic              take,
  output logic              active,
  output logic              bit_q
);
  localparam int CW = (WORD_W > 2) ? $clog2(WORD_W) : 1;
  localparam logic [CW-1:0] LAST = CW'(WORD_W - 1);

  logic [WORD_W-1:0] word_q;
  logic [CW-1:0]     cnt_q, nxt_cnt, nxt_idx;
  logic              fs_prev_q, sig_q, sigfr_q, sigfr_now, nxt_bit, rise;

  assign rise      = fs & ~fs_prev_q;
  assign take      = tick & ~active & rise;
  assign nxt_cnt   = cnt_q + 1'b1;
  assign nxt_idx   = LAST - nxt_cnt;
  assign sigfr_now = sigfr_q | (cnt_q == '0 && rate == RATE_FIXED && fs);
  assign nxt_bit   = (nxt_cnt == LAST && sigfr_now && !alaw_sel) ? sig_q
                                                                 : word_q[nxt_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_prev_q <= 1'b0;
      active    <= 1'b0;
      cnt_q     <= '0;
      word_q    <= '0;
      sig_q     <= 1'b0;
      sigfr_q   <= 1'b0;
      bit_q     <= 1'b0;
    end else begin
      if (tick) fs_prev_q <= fs;
      if (active && standby) begin
        active <= 1'b0;
      end else if (take) begin
        word_q  <= word_in;
        active  <= 1'b1;
        cnt_q   <= '0;
        sig_q   <= sig_in;
        sigfr_q <= 1'b0;
        bit_q   <= word_in[WORD_W-1];
      end else if (tick && active) begin
        if ((rate == RATE_VARIABLE && !fs) || cnt_q == LAST) begin
          active <= 1'b0;
        end else begin
          cnt_q <= nxt_cnt;
          bit_q <= nxt_bit;
          if (cnt_q == '0 && rate == RATE_FIXED && fs) sigfr_q <= 1'b1;
        end
      end
    end
  end

  // R2: the first bit of a timeslot is the word's top bit
  p_msb_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> (bit_q == $past(word_in[WORD_W-1])));
  // R6: variable-rate frames are never marked as signalling frames
  p_no_sig_variable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rate == RATE_VARIABLE && active && $stable(rate)) |=> !$rose(sigfr_q));
endmodule

// File: rtl/pcm_tx_fs_watch.sv
module pcm_tx_fs_watch #(
  parameter int LOSS_CYCLES = 240000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fs,
  output logic standby
);
  localparam int LW = $clog2(LOSS_CYCLES + 1);
  localparam logic [LW-1:0] LIMIT = LW'(LOSS_CYCLES - 1);

  logic [LW-1:0] low_cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt_q <= '0;
      standby   <= 1'b0;
    end else if (fs) begin
      low_cnt_q <= '0;
      standby   <= 1'b0;
    end else if (low_cnt_q == LIMIT) begin
      standby   <= 1'b1;
    end else begin
      low_cnt_q <= low_cnt_q + 1'b1;
    end
  end

  // R10: a high frame sync always leaves standby at the next edge
  p_standby_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fs |=> !standby);
endmodule

// File: rtl/pcm_tx_slot_serializer.sv
module pcm_tx_slot_serializer
  import pcm_tx_pkg::*;
#(
  parameter int WORD_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int LOSS_CYCLES = 240000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rate_sel,
  input  logic              alaw_sel,
  input  logic              dclk_ext,
  input  logic              fs,
  input  logic              sig_in,
  input  logic [WORD_W-1:0] word_data,
  input  logic              word_valid,
  output logic              word_ready,
  output logic              dx,
  output logic              dx_oe,
  output logic              ts_strobe,
  output logic              standby
);
  rate_e             rate;
  logic              tick, take, active, bit_q;
  logic [WORD_W-1:0] word_next;

  assign rate = rate_e'(rate_sel);

  pcm_tx_bit_clock #(.SYNC_STAGES(SYNC_STAGES)) u_clk (
    .clk(clk), .rst_n(rst_n), .rate(rate), .dclk_ext(dclk_ext), .tick(tick));

  pcm_tx_word_buffer #(.WORD_W(WORD_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .in_data(word_data), .in_valid(word_valid),
    .in_ready(word_ready), .take(take), .word_out(word_next));

  pcm_tx_slot_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rate(rate), .alaw_sel(alaw_sel),
    .fs(fs), .sig_in(sig_in), .standby(standby), .word_in(word_next),
    .take(take), .active(active), .bit_q(bit_q));

  pcm_tx_fs_watch #(.LOSS_CYCLES(LOSS_CYCLES)) u_watch (
    .clk(clk), .rst_n(rst_n), .fs(fs), .standby(standby));

  assign dx_oe     = active & ~standby;
  assign dx        = dx_oe & bit_q;
  assign ts_strobe = dx_oe & (rate == RATE_FIXED);

  // R10: the line is never driven in standby
  p_oe_off_standby_r10: assert property (@(posedge clk) disable iff (!rst_n)
    standby |-> !dx_oe);
  // R7: the strobe appears only in fixed mode, and only with the enable
  p_strobe_fixed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ts_strobe |-> (dx_oe && rate == RATE_FIXED));
  // R7: nothing is driven outside a timeslot
  p_dx_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !dx_oe |-> !dx);
endmodule

// File: tb/pcm_tx_slot_serializer_tb_top.sv
module pcm_tx_slot_serializer_tb_top;
  localparam int W    = 8;
  localparam int LOSS = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rate_sel = 1'b0, alaw_sel = 1'b0, dclk_ext = 1'b0, fs = 1'b0, sig_in = 1'b0;
  logic [W-1:0] word_data = '0;
  logic word_valid = 1'b0;
  logic word_ready, dx, dx_oe, ts_strobe, standby;

  int checks = 0, failures = 0;
  string tag = "R1";
  bit dclk_run = 1'b0;
  bit done = 1'b0;
  event dclk_fell;

  always #10 clk = ~clk;

  pcm_tx_slot_serializer #(.WORD_W(W), .SYNC_STAGES(2), .LOSS_CYCLES(LOSS)) dut_i (
    .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .alaw_sel(alaw_sel),
    .dclk_ext(dclk_ext), .fs(fs), .sig_in(sig_in), .word_data(word_data),
    .word_valid(word_valid), .word_ready(word_ready), .dx(dx), .dx_oe(dx_oe),
    .ts_strobe(ts_strobe), .standby(standby));

  // behavioural reference model
  bit m_active, m_sig, m_sigfr, m_dx, m_fsprev, m_full, m_sb;
  int m_cnt, m_low;
  bit [W-1:0] m_word, m_hold, m_last;
  bit d1, d2, d3;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_active = 0; m_sig = 0; m_sigfr = 0; m_dx = 0; m_fsprev = 0; m_full = 0;
      m_sb = 0; m_cnt = 0; m_low = 0; m_word = 0; m_hold = 0; m_last = 0;
      d1 = 0; d2 = 0; d3 = 0;
    end else begin
      bit tick, take, acc, was_active, was_sb;
      bit [W-1:0] w;
      tick = rate_sel ? (d2 && !d3) : 1'b1;
      acc = word_valid && !m_full;
      was_active = m_active; was_sb = m_sb;
      take = tick && !m_active && fs && !m_fsprev;
      w = m_full ? m_hold : m_last;
      if (tick) m_fsprev = fs;
      if (was_active && was_sb) m_active = 0;
      else if (take) begin
        m_word = w; m_active = 1; m_cnt = 0; m_sig = sig_in; m_sigfr = 0; m_dx = w[W-1];
      end else if (tick && was_active) begin
        if ((rate_sel && !fs) || m_cnt == W-1) m_active = 0;
        else begin
          bit sf;
          sf = m_sigfr || (m_cnt == 0 && !rate_sel && fs);
          m_cnt = m_cnt + 1;
          m_dx = (m_cnt == W-1 && sf && !alaw_sel) ? m_sig : m_word[W-1-m_cnt];
          m_sigfr = sf;
        end
      end
      if (acc) begin m_hold = word_data; m_full = 1; end
      else if (take) m_full = 0;
      if (take) m_last = w;
      if (fs) begin m_low = 0; m_sb = 0; end
      else if (m_low == LOSS-1) m_sb = 1;
      else m_low = m_low + 1;
      d3 = d2; d2 = d1; d1 = dclk_ext;
    end
  end

  task automatic check1(string req, string name, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, name, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit e_oe;
      e_oe = m_active && !m_sb;
      check1(tag, "dx_oe", dx_oe, e_oe);
      check1(tag, "dx", dx, e_oe && m_dx);
      check1("R7", "ts_strobe", ts_strobe, e_oe && !rate_sel);
      check1("R8", "word_ready", word_ready, !m_full);
      check1("R10", "standby", standby, m_sb);
    end
  end

  // external data clock: period of six system clocks
  initial begin
    int ph = 0;
    forever begin
      @(negedge clk);
      if (dclk_run) begin
        ph++;
        if (ph == 3) begin
          ph = 0;
          dclk_ext = ~dclk_ext;
          if (!dclk_ext) -> dclk_fell;
        end
      end
    end
  end

  task automatic push(logic [W-1:0] v);
    @(negedge clk);
    word_valid = 1'b1; word_data = v;
    while (!word_ready) @(negedge clk);
    @(negedge clk);
    word_valid = 1'b0;
  endtask

  task automatic fixed_frame(int width, logic s);
    @(negedge clk);
    sig_in = s; fs = 1'b1;
    repeat (width) @(negedge clk);
    fs = 1'b0;
    repeat (12) @(negedge clk);
  endtask

  task automatic var_frame(int periods, logic s);
    @(dclk_fell);
    sig_in = s; fs = 1'b1;
    repeat (periods) @(dclk_fell);
    fs = 1'b0;
    repeat (3) @(dclk_fell);
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check1("R1", "dx_oe", dx_oe, 1'b0);
    check1("R1", "dx", dx, 1'b0);
    check1("R1", "ts_strobe", ts_strobe, 1'b0);
    check1("R1", "standby", standby, 1'b0);
    check1("R1", "word_ready", word_ready, 1'b1);

    tag = "R2"; push(8'hA5); fixed_frame(1, 1'b1);
    push(8'h69); fixed_frame(1, 1'b0);
    tag = "R9"; fixed_frame(1, 1'b1);
    tag = "R4"; push(8'h3C); fixed_frame(2, 1'b1);
    push(8'hC3); fixed_frame(2, 1'b0);
    tag = "R5"; alaw_sel = 1'b1; push(8'h3C); fixed_frame(2, 1'b1);
    alaw_sel = 1'b0;
    tag = "R8"; push(8'h81);
    fork
      push(8'h7E);
      begin repeat (4) @(negedge clk); fixed_frame(1, 1'b0); end
    join
    fixed_frame(2, 1'b1);
    tag = "R10"; repeat (LOSS + 10) @(negedge clk);
    push(8'hF0); fixed_frame(1, 1'b0);

    tag = "R3"; rate_sel = 1'b1; dclk_run = 1'b1;
    repeat (2) @(dclk_fell);
    push(8'h5A); var_frame(8, 1'b1);
    push(8'h96); var_frame(3, 1'b0);
    tag = "R6"; push(8'h3E); var_frame(8, 1'b1);
    tag = "R10"; push(8'hB7);
    @(dclk_fell); fs = 1'b1;
    repeat (3) @(dclk_fell);
    dclk_run = 1'b0; fs = 1'b0;
    repeat (LOSS + 10) @(negedge clk);
    dclk_run = 1'b1;
    repeat (3) @(dclk_fell);
    rate_sel = 1'b0;
    tag = "R2"; fixed_frame(1, 1'b0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule